// File: doc/BRIEF.md
# Multiplexed Address/Data SRAM Port

This block models one port of a word-organised static memory whose single 16-bit bus carries both the address and the data. In multiplexed mode the host places an address on the shared bus and pulses the address-latch input low for one clock cycle. The port captures the address in that cycle. Every later read or write uses the captured address until the next latch pulse. Upper and lower byte enables select which 8-bit lanes take part in each access.

A mode-select input switches the port to a conventional arrangement. A dedicated 14-bit address input then feeds the array directly, and the latch input is ignored. The bidirectional pins are represented by a 16-bit data-out vector and a 2-bit per-lane drive enable. Read data and its lane enables appear one clock after the access controls are sampled. All controls are active-low and synchronous to the clock.

Top module: `muxbus_sram_port`

## Requirements
- R1: During and after reset, and until the first read, both lane drive enables are 0 and the data-out vector is 0. The held latch address resets to 0, so a multiplexed-mode access made before any latch pulse reaches word 0.
- R2: With mode_sel = 1, a cycle with adv_n = 0 stores ad_in[13:0] as the held address. Every later access in that mode uses the held address, which keeps its value through cycles with adv_n = 1.
- R3: In a latch cycle (mode_sel = 1 and adv_n = 0), the port neither reads nor writes, and both lane drive enables are 0 in the following cycle.
- R4: While cs_n = 1, no write changes the array, and both lane drive enables are 0 in the following cycle.
- R5: While oe_n = 1, both lane drive enables are 0 in the following cycle. A write still takes place when cs_n = 0 and we_n = 0.
- R6: While ub_n = 1 and lb_n = 1, nothing is written, and both lane drive enables are 0 in the following cycle.
- R7: A cycle with cs_n = 0, we_n = 1 and oe_n = 0, and not a latch cycle, is a read. In the next cycle, dq_oe[0] = ~lb_n and dq_oe[1] = ~ub_n. The data-out vector carries bits 7..0 of the addressed word on lane 0 and bits 15..8 on lane 1. A lane that is not driven reads as 0.
- R8: A cycle with cs_n = 0 and we_n = 0, and not a latch cycle, is a write, whatever the value of oe_n. Lane 0 (ad_in[7:0]) is written when lb_n = 0, and lane 1 (ad_in[15:8]) is written when ub_n = 0. A write never drives the bus in the next cycle.
- R9: With mode_sel = 0, the address is taken from addr_in and adv_n has no effect.
- R10: The array holds 2^WORD_AW words (1024 by default). A word is selected by the low WORD_AW bits of the 14-bit address, so addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_sel | input | 1 | 1 = multiplexed address/data, 0 = separate address bus |
| cs_n | input | 1 | Port select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address latch strobe, active low (multiplexed mode only) |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| ad_in | input | 16 | Shared bus as seen by the port: address in latch cycles, write data otherwise |
| addr_in | input | 14 | Dedicated address (separate-bus mode) |
| dq_out | output | 16 | Read data on the bus lanes; 0 on undriven lanes |
| dq_oe | output | 2 | Per-lane drive enable; bit 1 = upper, bit 0 = lower |

## Verification
The assertions take every control input to be a clean level that is sampled at the rising edge and never X once reset is released. They also take reset release to be aligned to the clock, so the cycle after an input is sampled is the first one in which its effect can be seen. The stimulus changes all inputs only on the falling edge and keeps reset low until the clock is running. It chooses every control from the full set of 0/1 combinations, including latch strobes in separate-bus mode and writes with oe_n high. It preloads every word before any read, so every check compares against defined data.

// File: rtl/muxsram_pkg.sv
package muxsram_pkg;

  // Decoded operation for one sampled cycle
  typedef struct packed {
    logic latch;  // address phase in multiplexed mode
    logic rd;     // read access
    logic wr;     // write access
  } msp_op_t;

endpackage

// File: rtl/msp_access_decode.sv
module msp_access_decode
  import muxsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             mux_mode,
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] be_n,
  output msp_op_t          op,
  output logic [LANES-1:0] lane_sel
);

  logic any_lane;
  logic active;

  always_comb begin
    lane_sel = ~be_n;
    any_lane = |lane_sel;
    op.latch = mux_mode & ~adv_n;
    // An address phase never doubles as a data access
    active   = ~cs_n & any_lane & ~op.latch;
    op.wr    = active & ~we_n;
    op.rd    = active & we_n & ~oe_n;
  end

endmodule

// File: rtl/msp_addr_path.sv
module msp_addr_path #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              latch_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] held_addr
);

  logic [ADDR_W-1:0] held_q;
  logic [ADDR_W-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (latch_stb) begin
      held_d = bus_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      held_q <= held_d;
    end
  end

  assign held_addr = held_q;
  assign eff_addr  = mux_mode ? held_q : addr_in;

  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> held_addr == $past(bus_addr));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> $stable(held_addr));

endmodule

// File: rtl/msp_word_array.sv
module msp_word_array #(
  parameter int WORD_AW = 10,
  parameter int LANES   = 2,
  parameter int BYTE_W  = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [WORD_AW-1:0]      word_addr,
  input  logic [LANES*BYTE_W-1:0] wdata,
  output logic [LANES*BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] bank [DEPTH];
    logic [BYTE_W-1:0] rd_q;
    logic              lane_wr;
    logic              lane_rd;

    assign lane_wr = wr_en & lane_sel[g];
    assign lane_rd = rd_en & lane_sel[g];

    always_ff @(posedge clk) begin
      if (lane_wr) begin
        bank[word_addr] <= wdata[g*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (lane_rd) begin
        rd_q <= bank[word_addr];
      end
    end

    assign rdata[g*BYTE_W +: BYTE_W] = rd_q;
  end

endmodule

// File: rtl/msp_lane_drive.sv
module msp_lane_drive #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [LANES-1:0]        lane_sel,
  input  logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES*BYTE_W-1:0] dq_out,
  output logic [LANES-1:0]        dq_oe
);

  logic [LANES-1:0] oe_q;
  logic [LANES-1:0] oe_d;

  always_comb begin
    oe_d = rd_en ? lane_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
    end else begin
      oe_q <= oe_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dq_out[g*BYTE_W +: BYTE_W] = oe_q[g] ? rdata[g*BYTE_W +: BYTE_W] : '0;
  end

  assign dq_oe = oe_q;

endmodule

// File: rtl/muxbus_sram_port.sv
module muxbus_sram_port
  import muxsram_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 14,
  parameter int WORD_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              adv_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [1:0]        dq_oe
);

  localparam int LANES  = 2;
  localparam int BYTE_W = DATA_W / LANES;

  msp_op_t           op;
  logic [LANES-1:0]  lane_sel;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] held_addr;
  logic [DATA_W-1:0] rdata;

  msp_access_decode #(.LANES(LANES)) u_decode (
    .mux_mode (mode_sel),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .adv_n    (adv_n),
    .be_n     ({ub_n, lb_n}),
    .op       (op),
    .lane_sel (lane_sel)
  );

  msp_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mux_mode  (mode_sel),
    .latch_stb (op.latch),
    .bus_addr  (ad_in[ADDR_W-1:0]),
    .addr_in   (addr_in),
    .eff_addr  (eff_addr),
    .held_addr (held_addr)
  );

  msp_word_array #(.WORD_AW(WORD_AW), .LANES(LANES), .BYTE_W(BYTE_W)) u_array (
    .clk       (clk),
    .wr_en     (op.wr),
    .rd_en     (op.rd),
    .lane_sel  (lane_sel),
    .word_addr (eff_addr[WORD_AW-1:0]),
    .wdata     (ad_in),
    .rdata     (rdata)
  );

  msp_lane_drive #(.LANES(LANES), .BYTE_W(BYTE_W)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (op.rd),
    .lane_sel (lane_sel),
    .rdata    (rdata),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  // Address bits above the array index alias onto the same words
  logic alias_bits_unused;
  logic held_addr_unused;
  if (WORD_AW < ADDR_W) begin : g_alias
    assign alias_bits_unused = ^eff_addr[ADDR_W-1:WORD_AW];
  end else begin : g_noalias
    assign alias_bits_unused = 1'b0;
  end
  assign held_addr_unused = ^held_addr;

  // R4
  desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> dq_oe == '0);

  // R5
  oe_off_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> dq_oe == '0);

  // R6
  no_lane_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ub_n && lb_n) |=> dq_oe == '0);

  // R3
  latch_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !adv_n) |=> dq_oe == '0);

  // R8
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> dq_oe == '0);

  // R7
  read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n && !(mode_sel && !adv_n))
      |=> dq_oe == $past({~ub_n, ~lb_n}));

endmodule

// File: tb/muxbus_sram_port_tb.sv
module muxbus_sram_port_tb_top;

  localparam int WORDS = 1024;

  logic        clk;
  logic        rst_n;
  logic        mode_sel, cs_n, we_n, oe_n, adv_n, ub_n, lb_n;
  logic [15:0] ad_in;
  logic [13:0] addr_in;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [15:0] mdl [WORDS];
  logic [13:0] m_held;

  muxbus_sram_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .adv_n(adv_n), .ub_n(ub_n), .lb_n(lb_n), .ad_in(ad_in),
    .addr_in(addr_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] seed_word(input int i);
    return 16'(i * 40503) ^ 16'h5A5A;
  endfunction

  task automatic check(input string tag, input logic [1:0] e_oe, input logic [15:0] e_out);
    n_checks++;
    if (dq_oe !== e_oe || dq_out !== e_out) begin
      n_errors++;
      $display("FAIL %s: dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
               tag, dq_oe, dq_out, e_oe, e_out);
    end
  endtask

  // Drive one cycle at the falling edge, predict, and check at the next falling edge
  task automatic step(input logic m, input logic cs, input logic we, input logic oe,
                      input logic adv, input logic ub, input logic lb,
                      input logic [15:0] bus, input logic [13:0] a, input string tag);
    logic        latch, acc, rd;
    logic [13:0] ea;
    logic [9:0]  idx;
    logic [1:0]  e_oe;
    logic [15:0] e_out;
    mode_sel = m; cs_n = cs; we_n = we; oe_n = oe; adv_n = adv;
    ub_n = ub; lb_n = lb; ad_in = bus; addr_in = a;
    latch = m && !adv;
    acc   = !cs && !(ub && lb) && !latch;
    ea    = m ? m_held : a;
    idx   = ea[9:0];
    rd    = acc && we && !oe;
    e_oe  = rd ? {!ub, !lb} : 2'b00;
    e_out = {e_oe[1] ? mdl[idx][15:8] : 8'h00, e_oe[0] ? mdl[idx][7:0] : 8'h00};
    if (acc && !we) begin
      if (!lb) mdl[idx][7:0]  = bus[7:0];
      if (!ub) mdl[idx][15:8] = bus[15:8];
    end
    if (latch) m_held = bus[13:0];
    @(negedge clk);
    check(tag, e_oe, e_out);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    rst_n = 1'b0;
    mode_sel = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; adv_n = 1'b1;
    ub_n = 1'b1; lb_n = 1'b1; ad_in = '0; addr_in = '0;
    m_held = '0;
    unused_seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 in reset", 2'b00, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 2'b00, 16'h0000);

    // Preload every word through the separate address bus
    for (int i = 0; i < WORDS; i++) begin
      mdl[i] = seed_word(i);
      step(0, 0, 0, 1, 1, 0, 0, seed_word(i), 14'(i), "R9 preload");
    end
    mdl[0] = seed_word(0);

    // R1: held address is 0 before any latch pulse
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R1 held addr zero");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R1 read data");
    // R9: adv ignored in separate-bus mode
    step(0, 0, 1, 0, 0, 0, 0, 16'h0, 14'd5, "R9 adv ignored");
    step(0, 1, 1, 1, 1, 1, 1, 16'h0, 14'd0, "R9 read data");
    // R10: aliasing above the array index
    step(0, 0, 1, 0, 1, 0, 0, 16'h0, 14'd5 + 14'd1024, "R10 alias read");
    step(0, 1, 1, 1, 1, 1, 1, 16'h0, 14'd0, "R10 read data");
    // R3: latch cycle with read controls does not drive
    step(1, 0, 1, 0, 0, 0, 0, 16'd7, 14'h0, "R3 latch no drive");
    // R2: read from latched address
    step(1, 0, 1, 0, 1, 0, 0, 16'hFFFF, 14'h0, "R2 latched read");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R2 read data");
    // R8: full write then read back
    step(1, 0, 0, 0, 1, 0, 0, 16'hBEEF, 14'h0, "R8 full write");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R8 read back");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R8 read data");
    // R8: lower-only write with oe low
    step(1, 0, 0, 0, 1, 1, 0, 16'h1234, 14'h0, "R8 lower write");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R8 lower read back");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R8 read data");
    // R4: deselected write ignored
    step(1, 1, 0, 0, 1, 0, 0, 16'hFFFF, 14'h0, "R4 deselected write");
    step(1, 1, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R4 deselected read");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R4 confirm");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R4 read data");
    // R5: output disabled read, write still occurs
    step(1, 0, 1, 1, 1, 0, 0, 16'h0, 14'h0, "R5 oe high read");
    step(1, 0, 0, 1, 1, 0, 0, 16'hC0DE, 14'h0, "R5 oe high write");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R5 confirm");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R5 read data");
    // R6: no lanes selected
    step(1, 0, 0, 0, 1, 1, 1, 16'h0F0F, 14'h0, "R6 no lane write");
    step(1, 0, 1, 0, 1, 1, 1, 16'h0, 14'h0, "R6 no lane read");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R6 confirm");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R6 read data");
    // R7: single-lane reads
    step(1, 0, 1, 0, 1, 1, 0, 16'h0, 14'h0, "R7 lower read");
    step(1, 0, 1, 0, 1, 0, 1, 16'h0, 14'h0, "R7 upper read");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R7 read data");
    // R3: write in a latch cycle is not performed
    step(1, 0, 0, 0, 0, 0, 0, 16'd9, 14'h0, "R3 latch write");
    step(1, 0, 1, 0, 1, 0, 0, 16'h0, 14'h0, "R3 confirm");
    step(1, 1, 1, 1, 1, 1, 1, 16'h0, 14'h0, "R3 read data");

    // Constrained random mix
    for (int n = 0; n < 6000; n++) begin
      logic m, cs, we, oe, adv, ub, lb;
      string tag;
      m   = ($urandom % 4) != 0;
      cs  = ($urandom % 5) == 0;
      we  = ($urandom % 2) == 0;
      oe  = ($urandom % 4) == 0;
      adv = ($urandom % 4) != 0;
      ub  = ($urandom % 4) == 0;
      lb  = ($urandom % 4) == 0;
      if (m && !adv)   tag = "R3 random";
      else if (cs)     tag = "R4 random";
      else if (ub && lb) tag = "R6 random";
      else if (!we)    tag = "R8 random";
      else if (oe)     tag = "R5 random";
      else if (m)      tag = "R2 random";
      else             tag = "R7 random";
      step(m, cs, we, oe, adv, ub, lb, 16'($urandom), 14'($urandom), tag);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule